// File: doc/BRIEF.md
# Macroblock Residual Reconstruction Engine

This engine rebuilds the decoded pixels of one 4:2:0 macroblock. It takes in 8-bit predicted pixels and 16-bit signed inverse-transform residuals, and it produces 8-bit reconstructed pixels. The macroblock is handled as six 8x8 blocks in a fixed sequence: four luma blocks (upper-left, upper-right, lower-left, lower-right) followed by the two chroma blocks. Inside each block the 64 samples are taken in raster order. The residuals live in a local buffer RAM with a fixed, unpacked layout: every block owns a 128-byte slot, whether or not it carries data.

A start pulse launches a macroblock and supplies a 6-bit coded-block mask. The engine reads residuals only for blocks whose mask bit is set. Each read residual is first clamped to the signed 9-bit range. It is then added to the predicted pixel, and the sum is clamped to 0..255. For a block whose mask bit is clear, the buffer is never read and each predicted pixel passes through unchanged.

The residual read for the next sample is issued in the same cycle that the current predicted pixel is accepted. As a result, fetching overlaps the predicted-pixel stream and no preload phase is needed. Both pixel streams use valid/ready handshakes. A one-cycle done pulse follows the last output pixel.

Top module: `mc_recon`

## Requirements
- R1: While reset is high and in the first idle cycle after it, out_valid, done, pred_ready and ram_rd_en are all 0.
- R2: start is taken only when the engine is idle; the mask is captured at that edge, and a start pulse during processing has no effect on reads or output pixels.
- R3: Output pixels leave in block order Y0, Y1, Y2, Y3, U, V, 64 raster-order samples per block, 384 pixels per macroblock; mask bit 5 belongs to Y0, bit 4 to Y1, bit 3 to Y2, bit 2 to Y3, bit 1 to U and bit 0 to V.
- R4: Residual sample s of block b is read from byte address b*128 + 2*s, with one-cycle read latency; each sample of a coded block is read exactly once per macroblock.
- R5: For a block whose mask bit is 0 the RAM is never read and every output pixel equals its predicted pixel.
- R6: A residual (two's complement, bit 15 sign) is clamped to -256..255 before the add, so large magnitudes never wrap.
- R7: Each coded output pixel equals clamp(pred + clamped residual) to 0..255.
- R8: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_data stays stable; no pixel is lost or repeated.
- R9: done is a single-cycle pulse in the cycle after the 384th output handshake, and a start in that same cycle is accepted.
- R10: With pred_valid and out_ready held high, pred_ready stays high from the cycle after start until all 384 predicted pixels are taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch one macroblock (taken when idle) |
| cbp | input | 6 | Coded-block mask, bit 5 = Y0 ... bit 0 = V |
| pred_valid | input | 1 | Predicted pixel valid |
| pred_data | input | 8 | Predicted pixel |
| pred_ready | output | 1 | Engine accepts a predicted pixel |
| out_valid | output | 1 | Reconstructed pixel valid |
| out_data | output | 8 | Reconstructed pixel |
| out_ready | input | 1 | Sink accepts the reconstructed pixel |
| done | output | 1 | One-cycle pulse after the last pixel leaves |
| ram_rd_en | output | 1 | Residual RAM read enable |
| ram_addr | output | 10 | Residual RAM byte address |
| ram_rdata | input | 16 | Residual RAM data, one cycle after the read |

## Verification
Three things can happen in a single cycle:
- the output register drains one pixel,
- it is refilled with the next one,
- the residual read for the sample after that is issued.

If the hold logic for the returned RAM word is wrong, this collision makes the design pair a residual with the wrong predicted pixel. The bench provokes the collision by toggling out_ready and pred_valid in co-prime patterns while coded and uncoded blocks alternate. It judges the result by checking every output pixel, in order, against precomputed values. A second collision, the done pulse and a new start in the same cycle, is driven at every macroblock boundary and judged by the read counts and pixel values of the following macroblock.

// File: rtl/mc_recon_pkg.sv
package mc_recon_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2
  } seq_state_e;
endpackage

// File: rtl/mc_recon_seq.sv
module mc_recon_seq
  import mc_recon_pkg::*;
#(
  parameter int NBLK    = 6,
  parameter int BLK_SMP = 64,
  parameter int BLK_W   = $clog2(NBLK),
  parameter int SMP_W   = $clog2(BLK_SMP),
  parameter int ADDR_W  = BLK_W + SMP_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [NBLK-1:0]   cbp,
  input  logic              pix_fire,
  input  logic              last_out_fire,
  output logic              run,
  output logic              cur_coded,
  output logic              cur_last,
  output logic              ram_rd_en,
  output logic [ADDR_W-1:0] ram_addr
);
  seq_state_e        state;
  logic [NBLK-1:0]   cbp_q;
  logic [BLK_W-1:0]  blk, nxt_blk, rd_blk;
  logic [SMP_W-1:0]  smp, nxt_smp, rd_smp;
  logic              start_ok;

  assign start_ok  = (state == ST_IDLE) && start;
  assign run       = (state == ST_RUN);
  assign cur_last  = (blk == BLK_W'(NBLK-1)) && (smp == SMP_W'(BLK_SMP-1));
  assign cur_coded = cbp_q[BLK_W'(NBLK-1) - blk];

  always_comb begin
    if (smp == SMP_W'(BLK_SMP-1)) begin
      nxt_blk = blk + BLK_W'(1);
      nxt_smp = '0;
    end else begin
      nxt_blk = blk;
      nxt_smp = smp + SMP_W'(1);
    end
  end

  // read for the next sample goes out with the acceptance of the current one
  always_comb begin
    ram_rd_en = 1'b0;
    rd_blk    = '0;
    rd_smp    = '0;
    if (start_ok) begin
      ram_rd_en = cbp[NBLK-1];
    end else if (run && pix_fire && !cur_last) begin
      rd_blk    = nxt_blk;
      rd_smp    = nxt_smp;
      ram_rd_en = cbp_q[BLK_W'(NBLK-1) - nxt_blk];
    end
  end

  assign ram_addr = {rd_blk, rd_smp, 1'b0};

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cbp_q <= '0;
      blk   <= '0;
      smp   <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          state <= ST_RUN;
          cbp_q <= cbp;
          blk   <= '0;
          smp   <= '0;
        end
        ST_RUN: if (pix_fire) begin
          if (cur_last) state <= ST_DRAIN;
          else begin
            blk <= nxt_blk;
            smp <= nxt_smp;
          end
        end
        ST_DRAIN: if (last_out_fire) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R4
  rd_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (run && ram_rd_en) |-> cbp_q[BLK_W'(NBLK-1) - ram_addr[ADDR_W-1 -: BLK_W]]);

  // R4
  rd_range_chk: assert property (@(posedge clk) disable iff (rst)
    ram_rd_en |-> (ram_addr[ADDR_W-1 -: BLK_W] < BLK_W'(NBLK)));

  // R2
  start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE) |=> $stable(cbp_q));
endmodule

// File: rtl/mc_recon_arith.sv
module mc_recon_arith #(
  parameter int PIX_W = 8,
  parameter int RES_W = 16
) (
  input  logic             coded,
  input  logic [RES_W-1:0] res,
  input  logic [PIX_W-1:0] pred,
  output logic [PIX_W-1:0] pix
);
  localparam int RSAT_W = PIX_W + 1;
  localparam int SUM_W  = PIX_W + 3;
  localparam logic signed [RES_W-1:0] RHI = RES_W'((1 << PIX_W) - 1);
  localparam logic signed [RES_W-1:0] RLO = -RHI - RES_W'(1);
  localparam logic signed [SUM_W-1:0] PHI = SUM_W'((1 << PIX_W) - 1);

  logic signed [RES_W-1:0]  rs;
  logic signed [RSAT_W-1:0] r9;
  logic signed [SUM_W-1:0]  sm;

  assign rs = res;

  always_comb begin
    if (!coded)        r9 = '0;
    else if (rs > RHI) r9 = RHI[RSAT_W-1:0];
    else if (rs < RLO) r9 = RLO[RSAT_W-1:0];
    else               r9 = rs[RSAT_W-1:0];
  end

  always_comb begin
    sm = $signed({3'b000, pred}) + SUM_W'(r9);
    if (sm < 0)        pix = '0;
    else if (sm > PHI) pix = PHI[PIX_W-1:0];
    else               pix = sm[PIX_W-1:0];
  end
endmodule

// File: rtl/mc_recon_ostage.sv
module mc_recon_ostage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         dlast,
  input  logic         ready,
  output logic         valid,
  output logic [W-1:0] data,
  output logic         last
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      data  <= '0;
      last  <= 1'b0;
    end else begin
      if (load) begin
        valid <= 1'b1;
        data  <= din;
        last  <= dlast;
      end else if (ready) begin
        valid <= 1'b0;
      end
    end
  end

  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (valid && !ready) |=> (valid && $stable(data)));
endmodule

// File: rtl/mc_recon.sv
module mc_recon #(
  parameter int NBLK    = 6,
  parameter int BLK_SMP = 64,
  parameter int PIX_W   = 8,
  parameter int RES_W   = 16,
  localparam int BLK_W  = $clog2(NBLK),
  localparam int SMP_W  = $clog2(BLK_SMP),
  localparam int ADDR_W = BLK_W + SMP_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [NBLK-1:0]   cbp,
  input  logic              pred_valid,
  input  logic [PIX_W-1:0]  pred_data,
  output logic              pred_ready,
  output logic              out_valid,
  output logic [PIX_W-1:0]  out_data,
  input  logic              out_ready,
  output logic              done,
  output logic              ram_rd_en,
  output logic [ADDR_W-1:0] ram_addr,
  input  logic [RES_W-1:0]  ram_rdata
);
  logic              run, cur_coded, cur_last, pix_fire, last_out_fire;
  logic              rd_pend, out_last;
  logic [RES_W-1:0]  res_hold, res_cur;
  logic [PIX_W-1:0]  pix;

  assign pred_ready    = run && (!out_valid || out_ready);
  assign pix_fire      = pred_valid && pred_ready;
  assign last_out_fire = out_valid && out_ready && out_last;

  mc_recon_seq #(
    .NBLK(NBLK), .BLK_SMP(BLK_SMP),
    .BLK_W(BLK_W), .SMP_W(SMP_W), .ADDR_W(ADDR_W)
  ) u_seq (
    .clk(clk), .rst(rst), .start(start), .cbp(cbp),
    .pix_fire(pix_fire), .last_out_fire(last_out_fire),
    .run(run), .cur_coded(cur_coded), .cur_last(cur_last),
    .ram_rd_en(ram_rd_en), .ram_addr(ram_addr)
  );

  // the RAM word is live only in the cycle after the read; keep it over stalls
  assign res_cur = rd_pend ? ram_rdata : res_hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_pend  <= 1'b0;
      res_hold <= '0;
      done     <= 1'b0;
    end else begin
      rd_pend  <= ram_rd_en;
      res_hold <= res_cur;
      done     <= last_out_fire;
    end
  end

  mc_recon_arith #(.PIX_W(PIX_W), .RES_W(RES_W)) u_arith (
    .coded(cur_coded), .res(res_cur), .pred(pred_data), .pix(pix)
  );

  mc_recon_ostage #(.W(PIX_W)) u_ostage (
    .clk(clk), .rst(rst), .load(pix_fire), .din(pix), .dlast(cur_last),
    .ready(out_ready), .valid(out_valid), .data(out_data), .last(out_last)
  );

  // R5
  uncoded_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (pix_fire && !cur_coded) |=> (out_data == $past(pred_data)));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R10
  ready_run_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !out_valid) |-> pred_ready);
endmodule

// File: tb/sim_mc_recon.sv
module sim_mc_recon;
  localparam int CLK_P = 10;
  localparam int NPIX  = 384;

  // stimulus/expected vectors: predicted pixel, residual word, expected coded result
  localparam logic [7:0] TP [16] = '{8'd100, 8'd10, 8'd200, 8'd0, 8'd255, 8'd128, 8'd50, 8'd250,
                                     8'd0, 8'd1, 8'd255, 8'd77, 8'd3, 8'd60, 8'd127, 8'd200};
  localparam logic [15:0] TR [16] = '{16'h0005, 16'hFED4, 16'h0190, 16'h00FF, 16'hFF00, 16'hFF80,
                                      16'hFFEC, 16'h000A, 16'hFFFF, 16'h7FFF, 16'h8000, 16'h0000,
                                      16'h0100, 16'hFE00, 16'h0080, 16'hFFFF};
  localparam logic [7:0] TE [16] = '{8'd105, 8'd0, 8'd255, 8'd255, 8'd0, 8'd0, 8'd30, 8'd255,
                                     8'd0, 8'd255, 8'd0, 8'd77, 8'd255, 8'd0, 8'd255, 8'd199};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [5:0] cbp = '0;
  logic pred_valid = 1'b0;
  logic [7:0] pred_data = '0;
  logic pred_ready, out_valid, out_ready, done, ram_rd_en;
  logic [7:0] out_data;
  logic [9:0] ram_addr;
  logic [15:0] ram_rdata = '0;
  logic [15:0] mem [NPIX];
  logic [5:0] cur_cbp = '0;

  int checks = 0;
  int fails = 0;
  int rd_cnt = 0;
  int bad_rd = 0;

  always #(CLK_P/2) clk = ~clk;

  assign out_ready = rdy_drv;
  logic rdy_drv = 1'b0;

  mc_recon u0 (
    .clk(clk), .rst(rst), .start(start), .cbp(cbp),
    .pred_valid(pred_valid), .pred_data(pred_data), .pred_ready(pred_ready),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
    .done(done), .ram_rd_en(ram_rd_en), .ram_addr(ram_addr), .ram_rdata(ram_rdata)
  );

  // residual RAM model: registered read, output holds between reads
  always @(posedge clk) begin
    if (ram_rd_en) begin
      ram_rdata <= mem[int'(ram_addr[9:1]) % NPIX];
      rd_cnt <= rd_cnt + 1;
      if (!cur_cbp[5 - int'(ram_addr[9:7])]) bad_rd <= bad_rd + 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // mode 0: no stalls; 1: co-prime stalls plus a stray start; 2: output ready every other cycle
  task automatic run_mb(input logic [5:0] mask, input int mode);
    int pi = 0;
    int oi = 0;
    int cyc = 0;
    int stalls = 0;
    int rd_base;
    int held = 0;
    logic [7:0] held_val = '0;
    logic [7:0] expv [NPIX];
    for (int i = 0; i < NPIX; i++)
      expv[i] = mask[5 - i/64] ? TE[i%16] : TP[i%16];
    rd_base = rd_cnt;
    cur_cbp = mask;
    start = 1'b1;
    cbp = mask;
    @(negedge clk);
    start = 1'b0;
    chk("R9 done single pulse", int'(done), 0);
    while (oi < NPIX) begin
      rdy_drv    = (mode == 0) ? 1'b1 : (mode == 1) ? ((cyc % 3) != 1) : ((cyc % 2) == 0);
      pred_valid = (pi < NPIX) && ((mode != 1) || ((cyc % 5) != 2));
      pred_data  = TP[pi%16];
      if (mode == 1 && cyc == 100) begin
        start = 1'b1;        // R2: stray start with an all-zero mask while busy
        cbp   = 6'b000000;
      end else begin
        start = 1'b0;
      end
      #1;
      if (held != 0) begin
        // R8: held pixel must still be offered unchanged
        chk("R8 valid held", int'(out_valid), 1);
        chk("R8 data held", int'(out_data), int'(held_val));
      end
      held = 0;
      if (out_valid && !out_ready) begin
        held = 1;
        held_val = out_data;
      end
      if (out_valid && out_ready) begin
        // R3 order, R7 coded value, R5 uncoded pass-through, R6 clamp
        chk(mask[5 - oi/64] ? "R3/R6/R7 pixel" : "R3/R5 pixel", int'(out_data), int'(expv[oi]));
        oi++;
      end
      if (pred_valid && pred_ready) pi++;
      else if (mode == 0 && pi < NPIX) stalls++;
      cyc++;
      if (cyc > 5000) begin
        chk("watchdog run", cyc, 0);
        break;
      end
      @(negedge clk);
    end
    start = 1'b0;
    pred_valid = 1'b0;
    // R9: done one cycle after the last output handshake
    chk("R9 done", int'(done), 1);
    // R4/R5: read count follows the mask, no read of an uncoded block
    chk("R4 read count", rd_cnt - rd_base, 64 * $countones(mask));
    chk("R5 no uncoded read", bad_rd, 0);
    if (mode == 0) chk("R10 pred stalls", stalls, 0);
  endtask

  initial begin
    #(CLK_P * 200000);
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails + 1);
    $finish;
  end

  initial begin
    for (int w = 0; w < NPIX; w++) mem[w] = TR[w%16];
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 out_valid", int'(out_valid), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 pred_ready", int'(pred_ready), 0);
    chk("R1 ram_rd_en", int'(ram_rd_en), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 idle pred_ready", int'(pred_ready), 0);
    chk("R1 idle out_valid", int'(out_valid), 0);
    run_mb(6'b111111, 0);
    run_mb(6'b101001, 1);   // started in the done cycle (R9), stray start (R2)
    run_mb(6'b000000, 2);
    run_mb(6'b010110, 0);
    @(negedge clk);
    chk("R9 done falls", int'(done), 0);
    chk("R1 back to idle", int'(pred_ready), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule